// File: doc/BRIEF.md
# Bridge Power and Fault Sequencer

This block decides, cycle by cycle, whether the H-bridge outputs, the charge pump and the step indexer of a two-phase stepper driver are allowed to run, and it drives the active-low fault flag seen by the host. It takes the synchronised outputs of the analog detectors as inputs:
- a deep supply undervoltage flag
- a shallow supply undervoltage flag
- a charge-pump undervoltage flag
- an over-temperature flag
- an overcurrent flag

It also takes the host's wake and output-enable controls and a select between latched and auto-retry overcurrent handling.

The two supply levels act differently. A dip below the shallow level only switches the power stage off, and the indexer keeps its position. A dip below the deep level acts as a logic reset and sends the indexer home. Sleep entry and wake-up are both delayed by counted intervals. Overcurrent is either held until the host pulses the enable low for long enough, or cleared automatically after a retry interval. All delays are parameters in clock cycles.

Top module: `bridge_power_ctrl`

## Requirements
- R1: While rst_ni is low, and in the first cycle after it, the block is asleep. In that state bridge_en_o=0, pump_en_o=0, idx_run_o=0, idx_rst_o=1 and fault_no=1.
- R2: While uv_deep_i=1, bridge_en_o=0, pump_en_o=0, idx_run_o=0, idx_rst_o=1 and fault_no=0 in the same cycle. On the next edge the sequencer returns to asleep and any held overcurrent is dropped.
- R3: From asleep, awake_i=1 starts a wake phase. idx_rst_o drops after the first edge. pump_en_o and idx_run_o rise only after WAKE_CYC further edges with awake_i held high. A low awake_i during the wake phase returns the sequencer to asleep.
- R4: After awake_i falls while running, outputs keep running for SLEEP_CYC edges and then turn off, with idx_rst_o=1. If awake_i returns high before that, running continues without a wake phase.
- R5: With out_en_i=0 and no fault, bridge_en_o=0 while pump_en_o=1, idx_run_o=1 and fault_no=1.
- R6: While running with uv_shallow_i=1, bridge_en_o=0, pump_en_o=0 and fault_no=0, while idx_run_o stays 1 and idx_rst_o stays 0. Recovery is immediate when the flag clears.
- R7: While running, cp_uv_i=1 or hot_i=1 clears bridge_en_o and pulls fault_no low, and leaves pump_en_o at 1. Both recover as soon as the flag clears.
- R8: With oc_retry_i=0, overcurrent seen while running holds bridge_en_o=0 and fault_no=0. The hold ends only on a rising out_en_i that follows at least ENLOW_CYC consecutive low cycles. A shorter low pulse leaves it held.
- R9: A held overcurrent is also cleared by the sequencer reaching asleep, or by uv_deep_i.
- R10: With oc_retry_i=1, overcurrent blocks the bridge and pulls fault_no low for RETRY_CYC cycles, then releases both. If oc_i is still high, the cycle repeats.
- R11: Fault reporting ranks the deep undervoltage first, then sleep, then all other faults. While asleep or waking, only uv_deep_i can pull fault_no low, and overcurrent is not captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| awake_i | input | 1 | Host wake request, 0 requests sleep |
| out_en_i | input | 1 | Host output enable |
| uv_shallow_i | input | 1 | Supply below upper undervoltage level |
| uv_deep_i | input | 1 | Supply below logic undervoltage level |
| cp_uv_i | input | 1 | Charge-pump undervoltage |
| hot_i | input | 1 | Over-temperature |
| oc_i | input | 1 | Overcurrent detected |
| oc_retry_i | input | 1 | 1 selects auto-retry, 0 latched overcurrent |
| bridge_en_o | output | 1 | H-bridge drive enable |
| pump_en_o | output | 1 | Charge-pump enable |
| idx_rst_o | output | 1 | Hold indexer at home position |
| idx_run_o | output | 1 | Indexer accepts step pulses |
| fault_no | output | 1 | Fault flag, active low |

## Verification
The bench aims at the off-by-one edges of every counted interval:
- A wake or sleep delay that is one cycle short would turn the pump on, or off, a cycle early.
- An enable-low qualifier that is one short would clear a latched overcurrent on a pulse of ENLOW_CYC-1 cycles.

It also checks that a shallow undervoltage leaves idx_run_o high, since a design that treated it like the deep level would lose step position. Faults are raised while asleep or waking: a design that ranked them wrongly would pull fault_no low, or capture an overcurrent that then lingers after wake-up. The retry path is run with oc_i held high, so that a design that retried only once would fail.

// File: rtl/pm_pkg.sv
package pm_pkg;
  typedef enum logic [1:0] {
    SL_ASLEEP = 2'd0,
    SL_WAKING = 2'd1,
    SL_ON     = 2'd2,
    SL_DOZE   = 2'd3
  } sleep_st_e;

  typedef enum logic [1:0] {
    OC_OK    = 2'd0,
    OC_LATCH = 2'd1,
    OC_RETRY = 2'd2
  } oc_st_e;
endpackage

// File: rtl/pm_sleep_seq.sv
module pm_sleep_seq
  import pm_pkg::*;
#(
  parameter int unsigned WAKE_CYC  = 16,
  parameter int unsigned SLEEP_CYC = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic awake_i,
  output logic on_o,
  output logic asleep_o
);
  localparam int unsigned MaxCyc = (WAKE_CYC > SLEEP_CYC) ? WAKE_CYC : SLEEP_CYC;
  localparam int unsigned CntW   = $clog2(MaxCyc + 1);
  localparam logic [CntW-1:0] WakeLast  = CntW'(WAKE_CYC - 1);
  localparam logic [CntW-1:0] SleepLast = CntW'(SLEEP_CYC - 1);

  sleep_st_e st_q, st_d;
  logic [CntW-1:0] cnt_q, cnt_d;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    if (clr_i) begin
      st_d  = SL_ASLEEP;
      cnt_d = '0;
    end else begin
      unique case (st_q)
        SL_ASLEEP: if (awake_i) begin
          st_d  = SL_WAKING;
          cnt_d = '0;
        end
        SL_WAKING: begin
          if (!awake_i) st_d = SL_ASLEEP;
          else if (cnt_q == WakeLast) st_d = SL_ON;
          else cnt_d = cnt_q + 1'b1;
        end
        SL_ON: if (!awake_i) begin
          st_d  = SL_DOZE;
          cnt_d = '0;
        end
        SL_DOZE: begin
          if (awake_i) st_d = SL_ON;
          else if (cnt_q == SleepLast) st_d = SL_ASLEEP;
          else cnt_d = cnt_q + 1'b1;
        end
        default: st_d = SL_ASLEEP;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= SL_ASLEEP;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign on_o     = (st_q == SL_ON) || (st_q == SL_DOZE);
  assign asleep_o = (st_q == SL_ASLEEP);

  // R3: no path from asleep straight to running
  a_r3_no_skip_wake: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == SL_ASLEEP) |=> (st_q != SL_ON));

  // R4: falling request starts the sleep delay, never an immediate stop
  a_r4_doze_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == SL_ON && !awake_i && !clr_i) |=> (st_q == SL_DOZE));

  // R2: deep undervoltage returns the sequencer to asleep
  a_r2_deep_resets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (st_q == SL_ASLEEP));
endmodule

// File: rtl/pm_oc_ctrl.sv
module pm_oc_ctrl
  import pm_pkg::*;
#(
  parameter int unsigned RETRY_CYC = 64,
  parameter int unsigned ENLOW_CYC = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic arm_i,
  input  logic oc_i,
  input  logic retry_mode_i,
  input  logic en_i,
  output logic block_o
);
  localparam int unsigned MaxCyc = (RETRY_CYC > ENLOW_CYC) ? RETRY_CYC : ENLOW_CYC;
  localparam int unsigned CntW   = $clog2(MaxCyc + 1);
  localparam logic [CntW-1:0] RetryLast = CntW'(RETRY_CYC - 1);
  localparam logic [CntW-1:0] EnLowMin  = CntW'(ENLOW_CYC);

  oc_st_e st_q, st_d;
  logic [CntW-1:0] cnt_q, cnt_d;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    if (clr_i) begin
      st_d  = OC_OK;
      cnt_d = '0;
    end else begin
      unique case (st_q)
        OC_OK: if (arm_i && oc_i) begin
          st_d  = retry_mode_i ? OC_RETRY : OC_LATCH;
          cnt_d = '0;
        end
        OC_LATCH: begin
          if (!en_i) begin
            if (cnt_q < EnLowMin) cnt_d = cnt_q + 1'b1;
          end else begin
            if (cnt_q >= EnLowMin) st_d = OC_OK;
            cnt_d = '0;
          end
        end
        OC_RETRY: begin
          if (cnt_q == RetryLast) begin
            st_d  = OC_OK;
            cnt_d = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        default: st_d = OC_OK;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= OC_OK;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign block_o = (st_q != OC_OK);

  // R8: a short enable-low pulse never frees a latched fault
  a_r8_short_pulse_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == OC_LATCH && !clr_i && en_i && cnt_q < EnLowMin) |=> (st_q == OC_LATCH));

  // R10: retry never turns into a latch
  a_r10_retry_no_latch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == OC_RETRY) |=> (st_q != OC_LATCH));

  // R11: nothing is captured while the sequencer is not running
  a_r11_no_capture_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == OC_OK && !arm_i) |=> (st_q == OC_OK));
endmodule

// File: rtl/bridge_power_ctrl.sv
module bridge_power_ctrl #(
  parameter int unsigned WAKE_CYC  = 250,
  parameter int unsigned SLEEP_CYC = 250,
  parameter int unsigned RETRY_CYC = 1000,
  parameter int unsigned ENLOW_CYC = 250
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic awake_i,
  input  logic out_en_i,
  input  logic uv_shallow_i,
  input  logic uv_deep_i,
  input  logic cp_uv_i,
  input  logic hot_i,
  input  logic oc_i,
  input  logic oc_retry_i,
  output logic bridge_en_o,
  output logic pump_en_o,
  output logic idx_rst_o,
  output logic idx_run_o,
  output logic fault_no
);
  logic seq_on, seq_asleep, oc_block, run;

  pm_sleep_seq #(
    .WAKE_CYC (WAKE_CYC),
    .SLEEP_CYC(SLEEP_CYC)
  ) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (uv_deep_i),
    .awake_i (awake_i),
    .on_o    (seq_on),
    .asleep_o(seq_asleep)
  );

  pm_oc_ctrl #(
    .RETRY_CYC(RETRY_CYC),
    .ENLOW_CYC(ENLOW_CYC)
  ) u_oc (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (uv_deep_i || seq_asleep),
    .arm_i       (run),
    .oc_i        (oc_i),
    .retry_mode_i(oc_retry_i),
    .en_i        (out_en_i),
    .block_o     (oc_block)
  );

  assign run         = seq_on && !uv_deep_i;
  assign idx_run_o   = run;
  assign idx_rst_o   = seq_asleep || uv_deep_i;
  assign pump_en_o   = run && !uv_shallow_i;
  assign bridge_en_o = pump_en_o && out_en_i && !cp_uv_i && !hot_i && !oc_block;
  assign fault_no    = !(uv_deep_i || (run && (uv_shallow_i || cp_uv_i || hot_i || oc_block)));

  // R11: with the indexer stopped, only the deep level may report
  a_r11_quiet_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!idx_run_o && !uv_deep_i) |-> fault_no);

  // R6: shallow undervoltage never disturbs the indexer position
  a_r6_index_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idx_run_o && uv_shallow_i) |-> !idx_rst_o);

  // R7: bridge drive implies the pump is up
  a_r7_bridge_needs_pump: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bridge_en_o |-> pump_en_o);
endmodule

// File: tb/bridge_power_ctrl_tb_top.sv
`timescale 1ns/1ps
module bridge_power_ctrl_tb_top;
  localparam int W = 5, S = 7, RT = 10, EL = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic awake = 0, en = 0, uvs = 0, uvd = 0, cpuv = 0, hot = 0, oc = 0, rtry = 0;
  logic bridge, pump, irst, irun, fault_n;
  int vectors = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  bridge_power_ctrl #(.WAKE_CYC(W), .SLEEP_CYC(S), .RETRY_CYC(RT), .ENLOW_CYC(EL)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .awake_i(awake), .out_en_i(en),
    .uv_shallow_i(uvs), .uv_deep_i(uvd), .cp_uv_i(cpuv), .hot_i(hot), .oc_i(oc),
    .oc_retry_i(rtry), .bridge_en_o(bridge), .pump_en_o(pump), .idx_rst_o(irst),
    .idx_run_o(irun), .fault_no(fault_n));

  // reference model: 0 asleep, 1 waking, 2 on, 3 doze; oc 0 ok, 1 latch, 2 retry
  int m_sl = 0, m_sc = 0, m_oc = 0, m_oc_c = 0;

  function automatic bit m_run();
    return (m_sl >= 2) && !uvd;
  endfunction

  function automatic logic [4:0] m_out();
    logic b, p, r, n, f;
    n = m_run();
    r = (m_sl == 0) || uvd;
    p = n && !uvs;
    b = p && en && !cpuv && !hot && (m_oc == 0);
    f = !(uvd || (n && (uvs || cpuv || hot || m_oc != 0)));
    return {b, p, r, n, f};
  endfunction

  task automatic m_edge();
    int nsl = m_sl, nsc = m_sc, noc = m_oc, nocc = m_oc_c;
    bit arm = m_run();
    bit clr_oc = uvd || (m_sl == 0);
    if (uvd) begin nsl = 0; nsc = 0; end
    else case (m_sl)
      0: if (awake) begin nsl = 1; nsc = 0; end
      1: if (!awake) nsl = 0; else if (m_sc == W-1) nsl = 2; else nsc = m_sc + 1;
      2: if (!awake) begin nsl = 3; nsc = 0; end
      default: if (awake) nsl = 2; else if (m_sc == S-1) nsl = 0; else nsc = m_sc + 1;
    endcase
    if (clr_oc) begin noc = 0; nocc = 0; end
    else case (m_oc)
      0: if (arm && oc) begin noc = rtry ? 2 : 1; nocc = 0; end
      1: if (!en) begin if (m_oc_c < EL) nocc = m_oc_c + 1; end
         else begin if (m_oc_c >= EL) noc = 0; nocc = 0; end
      default: if (m_oc_c == RT-1) begin noc = 0; nocc = 0; end else nocc = m_oc_c + 1;
    endcase
    m_sl = nsl; m_sc = nsc; m_oc = noc; m_oc_c = nocc;
  endtask

  function automatic string auto_tag();
    if (!rst_n) return "R1";
    if (uvd) return "R2";
    if (m_sl == 1) return "R3";
    if (m_sl == 3) return "R4";
    if (m_sl == 0) return "R11";
    if (m_oc == 1) return "R8";
    if (m_oc == 2) return "R10";
    if (uvs) return "R6";
    if (cpuv || hot) return "R7";
    if (!en) return "R5";
    return "R9";
  endfunction

  task automatic cyc(input string tag);
    logic [4:0] act, exp;
    @(posedge clk);
    if (!rst_n) begin m_sl = 0; m_sc = 0; m_oc = 0; m_oc_c = 0; end
    else m_edge();
    #1;
    act = {bridge, pump, irst, irun, fault_n};
    exp = m_out();
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s t=%0t {bridge,pump,idx_rst,idx_run,fault_n} act=%b exp=%b",
               (tag == "") ? auto_tag() : tag, $time, act, exp);
    end
  endtask

  task automatic run_n(input int n, input string tag);
    for (int i = 0; i < n; i++) cyc(tag);
  endtask

  initial begin
    #400000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    run_n(3, "R1");            // reset state
    rst_n = 1'b1;
    run_n(1, "R1");
    awake = 1; en = 1;
    run_n(W + 3, "R3");        // wake delay boundary
    en = 0; run_n(3, "R5"); en = 1; run_n(1, "R5");
    uvs = 1; run_n(3, "R6"); uvs = 0; run_n(1, "R6");
    cpuv = 1; run_n(2, "R7"); cpuv = 0; hot = 1; run_n(2, "R7"); hot = 0; run_n(1, "R7");
    // latched overcurrent, short then qualified enable-low pulse
    rtry = 0; oc = 1; run_n(1, "R8"); oc = 0; run_n(3, "R8");
    en = 0; run_n(EL - 1, "R8"); en = 1; run_n(3, "R8");
    en = 0; run_n(EL, "R8"); en = 1; run_n(3, "R8");
    // latch cleared by sleep, then by deep undervoltage
    oc = 1; run_n(1, "R9"); oc = 0; awake = 0; run_n(S + 3, "R9");
    awake = 1; run_n(W + 3, "R9");
    oc = 1; run_n(1, "R9"); oc = 0; run_n(2, "R9");
    uvd = 1; run_n(2, "R2"); uvd = 0; run_n(W + 4, "R9");
    // retry with persistent fault
    rtry = 1; oc = 1; run_n(3 * RT + 2, "R10"); oc = 0; run_n(RT + 2, "R10");
    // sleep cancel and full sleep
    awake = 0; run_n(S - 1, "R4"); awake = 1; run_n(3, "R4");
    awake = 0; run_n(S + 2, "R4");
    hot = 1; oc = 1; cpuv = 1; uvs = 1; run_n(3, "R11");
    awake = 1; run_n(W - 1, "R11"); hot = 0; oc = 0; cpuv = 0; uvs = 0; run_n(4, "R11");
    uvd = 1; run_n(2, "R2"); uvd = 0;
    // constrained random
    for (int i = 0; i < 4000; i++) begin
      if ($urandom % 60 == 0) awake = ~awake;
      if ($urandom % 12 == 0) en = ~en;
      if ($urandom % 40 == 0) uvs = ~uvs;
      if ($urandom % 50 == 0) hot = ~hot;
      if ($urandom % 150 == 0) rtry = ~rtry;
      cpuv = ($urandom % 30 == 0);
      oc   = ($urandom % 25 == 0);
      uvd  = ($urandom % 400 == 0);
      cyc("");
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule